// File: doc/BRIEF.md
# Repeated-Block DMA Address Generator

This block produces the running source and destination addresses for one DMA channel. The channel moves a block of bytes as a series of bursts, and it may run the same block again a set number of times. The generator does not move any data. An external engine reports each finished source burst together with its byte count. It also reports each finished destination burst and the end of each block. The generator answers by stepping its addresses and counters.

Two separate offsets drive the address updates. A burst offset is applied after every burst. A block offset is applied when a block closes and a repeat follows. Each of the four updates has its own add-or-subtract choice: source per burst, destination per burst, source per block and destination per block. The start strobe captures all offsets, direction bits, start addresses, the block size and the repeat count. These held copies stay fixed until the next start.

Top module: `rblk_addr_gen`

## Requirements
- R1: After reset, both addresses, the remaining byte count, the remaining repeat count, `busy`, `xferDone` and `overrunErr` are all zero.
- R2: A `start` pulse loads the configured source address, destination address, byte count (`cfgBlkBytes`, 16 bits) and repeat count (`cfgRepeat`, 11 bits). It sets `busy` and clears `overrunErr`, all on the next clock edge. A `start` pulse wins over any other strobe in the same cycle.
- R3: While busy, `srcBurstDone` moves `srcAddr` by the held burst offset. The move is an add if the held `cfgSrcDec` bit is 0 and a subtract if it is 1. The remaining byte count drops by `burstBytes`.
- R4: While busy, `dstBurstDone` moves `dstAddr` by the held burst offset. The move is an add if the held `cfgDstDec` bit is 0 and a subtract if it is 1.
- R5: While busy, `blockDone` closes a block if the remaining byte count is zero and the repeat count is nonzero. On that edge, `srcAddr` moves by the held block offset (add if `cfgBlkSrcDec`=0, subtract if 1). `dstAddr` moves by the held block offset (add if `cfgBlkDstDec`=0, subtract if 1). The byte count reloads from the held block size, and the repeat count drops by one. A burst step in the same cycle adds on top of the block step.
- R6: A `blockDone` pulse has no effect while the remaining byte count is nonzero.
- R7: A `blockDone` pulse with zero bytes and zero repeats left ends the transfer. `xferDone` is high for exactly one cycle and `busy` falls. No block offset is applied. After that, strobes leave the addresses and counts unchanged until the next `start`.
- R8: A source burst that reports more bytes than remain only takes the count down to zero. It also sets `overrunErr`, which stays set until the next `start`.
- R9: Address arithmetic wraps modulo 2^32 in both directions.
- R10: Changes to the offset, direction, size or address configuration inputs while busy have no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture configuration and begin a transfer |
| cfgSrcAddr | input | 32 | Initial source address |
| cfgDstAddr | input | 32 | Initial destination address |
| cfgBlkBytes | input | 16 | Bytes per block |
| cfgRepeat | input | 11 | Extra block passes after the first |
| cfgBurstOff | input | 16 | Per-burst address offset |
| cfgBlockOff | input | 16 | Per-block address offset |
| cfgSrcDec | input | 1 | Source burst step subtracts when 1 |
| cfgDstDec | input | 1 | Destination burst step subtracts when 1 |
| cfgBlkSrcDec | input | 1 | Source block step subtracts when 1 |
| cfgBlkDstDec | input | 1 | Destination block step subtracts when 1 |
| srcBurstDone | input | 1 | A source burst finished |
| burstBytes | input | 16 | Bytes moved by that source burst |
| dstBurstDone | input | 1 | A destination burst finished |
| blockDone | input | 1 | The engine reports end of block |
| srcAddr | output | 32 | Current source address |
| dstAddr | output | 32 | Current destination address |
| bytesLeft | output | 16 | Bytes remaining in the current block |
| repeatLeft | output | 11 | Block passes remaining |
| busy | output | 1 | Transfer active |
| xferDone | output | 1 | One-cycle end-of-transfer pulse |
| overrunErr | output | 1 | Sticky burst overrun flag |

## Verification
The key collision is a burst step and a block step on the same clock edge, where both offsets must sum into one address. The bench raises `dstBurstDone` and `blockDone` together, and `srcBurstDone` and `blockDone` together. The expected addresses are worked out by hand and also tracked by the behavioural model on every clock. The second collision is an overrunning source burst that lands exactly on a block boundary. The bench judges it by the clamped count of zero and by the sticky error flag.

// File: rtl/rblk_pkg.sv
package rblk_pkg;
  typedef struct packed {
    logic load;
    logic srcStep;
    logic dstStep;
    logic blkStep;
  } rblkCtl_t;
endpackage

// File: rtl/rblk_addr_lane.sv
module rblk_addr_lane #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] loadVal,
  input  logic              burstStep,
  input  logic              blkStep,
  input  logic [OFF_W-1:0]  burstOff,
  input  logic [OFF_W-1:0]  blkOff,
  input  logic              burstDec,
  input  logic              blkDec,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] burstExt, blkExt, burstDelta, blkDelta;

  always_comb begin
    burstExt   = {{PAD_W{1'b0}}, burstOff};
    blkExt     = {{PAD_W{1'b0}}, blkOff};
    burstDelta = '0;
    blkDelta   = '0;
    if (burstStep) burstDelta = burstDec ? (~burstExt + 1'b1) : burstExt;
    if (blkStep)   blkDelta   = blkDec   ? (~blkExt + 1'b1)   : blkExt;
  end

  always_ff @(posedge clk) begin
    if (!rstN)     addr <= '0;
    else if (load) addr <= loadVal;
    else           addr <= addr + burstDelta + blkDelta;
  end
endmodule

// File: rtl/rblk_dpath.sv
module rblk_dpath
  import rblk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rblkCtl_t          ctl,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [OFF_W-1:0]  cfgBurstOff,
  input  logic [OFF_W-1:0]  cfgBlockOff,
  input  logic [3:0]        cfgDirs,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr
);
  localparam int LANES = 2;

  logic [OFF_W-1:0]  burstOffQ, blkOffQ;
  logic [3:0]        dirQ;
  logic [ADDR_W-1:0] laneInit [LANES];
  logic [ADDR_W-1:0] laneAddr [LANES];
  logic [LANES-1:0]  laneBurst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstOffQ <= '0;
      blkOffQ   <= '0;
      dirQ      <= '0;
    end else if (ctl.load) begin
      burstOffQ <= cfgBurstOff;
      blkOffQ   <= cfgBlockOff;
      dirQ      <= cfgDirs;
    end
  end

  assign laneInit[0] = cfgSrcAddr;
  assign laneInit[1] = cfgDstAddr;
  assign laneBurst   = {ctl.dstStep, ctl.srcStep};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rblk_addr_lane #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .load     (ctl.load),
      .loadVal  (laneInit[i]),
      .burstStep(laneBurst[i]),
      .blkStep  (ctl.blkStep),
      .burstOff (burstOffQ),
      .blkOff   (blkOffQ),
      .burstDec (dirQ[i]),
      .blkDec   (dirQ[2+i]),
      .addr     (laneAddr[i])
    );
  end

  assign srcAddr = laneAddr[0];
  assign dstAddr = laneAddr[1];
endmodule

// File: rtl/rblk_ctrl.sv
module rblk_ctrl
  import rblk_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             srcBurstDone,
  input  logic             dstBurstDone,
  input  logic             blockDone,
  input  logic [CNT_W-1:0] burstBytes,
  input  logic [CNT_W-1:0] cfgBlkBytes,
  input  logic [REP_W-1:0] cfgRepeat,
  output rblkCtl_t         ctl,
  output logic [CNT_W-1:0] bytesLeft,
  output logic [REP_W-1:0] repeatLeft,
  output logic             busy,
  output logic             xferDone,
  output logic             overrunErr
);
  logic [CNT_W-1:0] blkBytesQ;
  logic [CNT_W-1:0] takeBytes;
  logic             blockEmpty, lastPass, finish, overrun;

  always_comb begin
    blockEmpty  = (bytesLeft == '0);
    lastPass    = (repeatLeft == '0);
    overrun     = burstBytes > bytesLeft;
    takeBytes   = overrun ? bytesLeft : burstBytes;
    ctl.load    = start;
    ctl.srcStep = busy && !start && srcBurstDone;
    ctl.dstStep = busy && !start && dstBurstDone;
    ctl.blkStep = busy && !start && blockDone && blockEmpty && !lastPass;
    finish      = busy && !start && blockDone && blockEmpty && lastPass;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkBytesQ  <= '0;
      bytesLeft  <= '0;
      repeatLeft <= '0;
      busy       <= 1'b0;
      xferDone   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      xferDone <= finish;
      if (start) begin
        blkBytesQ  <= cfgBlkBytes;
        bytesLeft  <= cfgBlkBytes;
        repeatLeft <= cfgRepeat;
        busy       <= 1'b1;
        overrunErr <= 1'b0;
      end else begin
        if (ctl.srcStep && overrun) overrunErr <= 1'b1;
        if (ctl.blkStep) begin
          bytesLeft  <= blkBytesQ;
          repeatLeft <= repeatLeft - 1'b1;
        end else if (ctl.srcStep) begin
          bytesLeft <= bytesLeft - takeBytes;
        end
        if (finish) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rblk_addr_gen.sv
module rblk_addr_gen
  import rblk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REP_W  = 11,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [CNT_W-1:0]  cfgBlkBytes,
  input  logic [REP_W-1:0]  cfgRepeat,
  input  logic [OFF_W-1:0]  cfgBurstOff,
  input  logic [OFF_W-1:0]  cfgBlockOff,
  input  logic              cfgSrcDec,
  input  logic              cfgDstDec,
  input  logic              cfgBlkSrcDec,
  input  logic              cfgBlkDstDec,
  input  logic              srcBurstDone,
  input  logic [CNT_W-1:0]  burstBytes,
  input  logic              dstBurstDone,
  input  logic              blockDone,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  bytesLeft,
  output logic [REP_W-1:0]  repeatLeft,
  output logic              busy,
  output logic              xferDone,
  output logic              overrunErr
);
  rblkCtl_t ctl;

  rblk_ctrl #(.CNT_W(CNT_W), .REP_W(REP_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .srcBurstDone(srcBurstDone),
    .dstBurstDone(dstBurstDone),
    .blockDone   (blockDone),
    .burstBytes  (burstBytes),
    .cfgBlkBytes (cfgBlkBytes),
    .cfgRepeat   (cfgRepeat),
    .ctl         (ctl),
    .bytesLeft   (bytesLeft),
    .repeatLeft  (repeatLeft),
    .busy        (busy),
    .xferDone    (xferDone),
    .overrunErr  (overrunErr)
  );

  rblk_dpath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cfgSrcAddr (cfgSrcAddr),
    .cfgDstAddr (cfgDstAddr),
    .cfgBurstOff(cfgBurstOff),
    .cfgBlockOff(cfgBlockOff),
    .cfgDirs    ({cfgBlkDstDec, cfgBlkSrcDec, cfgDstDec, cfgSrcDec}),
    .srcAddr    (srcAddr),
    .dstAddr    (dstAddr)
  );
endmodule

// File: rtl/rblk_addr_gen_chk.sv
module rblk_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REP_W  = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              srcBurstDone,
  input logic              dstBurstDone,
  input logic              blockDone,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [ADDR_W-1:0] dstAddr,
  input logic [CNT_W-1:0]  bytesLeft,
  input logic [REP_W-1:0]  repeatLeft,
  input logic              busy,
  input logic              xferDone,
  input logic              overrunErr
);
  // R2
  start_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> busy && !overrunErr);

  // R3
  src_count_falls_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !start && srcBurstDone && !blockDone |=> bytesLeft <= $past(bytesLeft));

  // R5
  block_repeat_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !start && blockDone && bytesLeft == '0 && repeatLeft != '0
    |=> repeatLeft == $past(repeatLeft) - 1'b1);

  // R6
  block_early_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !start && blockDone && !srcBurstDone && bytesLeft != '0
    |=> $stable(bytesLeft) && $stable(repeatLeft));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> !busy);

  // R7
  idle_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !start |=> $stable(srcAddr) && $stable(dstAddr) && $stable(bytesLeft));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr && !start |=> overrunErr);

  // R8
  err_needs_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(srcBurstDone) && $past(busy));

  // R4
  dst_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !start && !dstBurstDone && !blockDone |=> $stable(dstAddr));
endmodule

bind rblk_addr_gen rblk_addr_gen_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REP_W(REP_W)
) u_chk (.*);

// File: tb/test_rblk_addr_gen.sv
module test_rblk_addr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cfgSrcAddr = '0, cfgDstAddr = '0;
  logic [15:0] cfgBlkBytes = '0;
  logic [10:0] cfgRepeat = '0;
  logic [15:0] cfgBurstOff = '0, cfgBlockOff = '0;
  logic        cfgSrcDec = 1'b0, cfgDstDec = 1'b0, cfgBlkSrcDec = 1'b0, cfgBlkDstDec = 1'b0;
  logic        srcBurstDone = 1'b0, dstBurstDone = 1'b0, blockDone = 1'b0;
  logic [15:0] burstBytes = '0;
  logic [31:0] srcAddr, dstAddr;
  logic [15:0] bytesLeft;
  logic [10:0] repeatLeft;
  logic        busy, xferDone, overrunErr;

  int nChk = 0;
  int nFail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rblk_addr_gen i_rblk_addr_gen (.*);

  // behavioural reference state
  logic [31:0] mSrc, mDst, hBurst, hBlk;
  logic [15:0] mBytes, hBytes, take;
  logic [10:0] mRep;
  logic        mBusy, mDone, mErr, hSd, hDd, hBsd, hBdd, endBlk;

  always @(posedge clk) begin
    if (!rstN) begin
      mSrc = 0; mDst = 0; mBytes = 0; mRep = 0;
      mBusy = 0; mDone = 0; mErr = 0;
      hBurst = 0; hBlk = 0; hBytes = 0;
      hSd = 0; hDd = 0; hBsd = 0; hBdd = 0;
    end else begin
      mDone = 0;
      if (start) begin
        mSrc = cfgSrcAddr; mDst = cfgDstAddr;
        mBytes = cfgBlkBytes; hBytes = cfgBlkBytes; mRep = cfgRepeat;
        hBurst = {16'h0, cfgBurstOff}; hBlk = {16'h0, cfgBlockOff};
        hSd = cfgSrcDec; hDd = cfgDstDec; hBsd = cfgBlkSrcDec; hBdd = cfgBlkDstDec;
        mBusy = 1; mErr = 0;
      end else if (mBusy) begin
        take = burstBytes;
        if (srcBurstDone) begin
          mSrc = hSd ? mSrc - hBurst : mSrc + hBurst;
          if (burstBytes > mBytes) begin mErr = 1; take = mBytes; end
        end
        if (dstBurstDone) mDst = hDd ? mDst - hBurst : mDst + hBurst;
        endBlk = blockDone && (mBytes == 0);
        if (endBlk && mRep == 0) begin
          mBusy = 0; mDone = 1;
        end else if (endBlk) begin
          mSrc = hBsd ? mSrc - hBlk : mSrc + hBlk;
          mDst = hBdd ? mDst - hBlk : mDst + hBlk;
          mBytes = hBytes; mRep = mRep - 1;
        end else if (srcBurstDone) begin
          mBytes = mBytes - take;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // lockstep comparison every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R3 src model", srcAddr, mSrc);
      chk("R4 dst model", dstAddr, mDst);
      chk("R5 bytes model", {16'h0, bytesLeft}, {16'h0, mBytes});
      chk("R5 repeat model", {21'h0, repeatLeft}, {21'h0, mRep});
      chk("R7 busy model", {31'h0, busy}, {31'h0, mBusy});
      chk("R7 done model", {31'h0, xferDone}, {31'h0, mDone});
      chk("R8 err model", {31'h0, overrunErr}, {31'h0, mErr});
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  // drive strobes for one clock, then release them
  task automatic pulse(input logic s, input logic sb, input logic [15:0] nb,
                       input logic db, input logic bd);
    start = s; srcBurstDone = sb; burstBytes = nb; dstBurstDone = db; blockDone = bd;
    @(negedge clk);
    start = 0; srcBurstDone = 0; burstBytes = 0; dstBurstDone = 0; blockDone = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 src", srcAddr, 0);
    chk("R1 dst", dstAddr, 0);
    chk("R1 bytes", {16'h0, bytesLeft}, 0);
    chk("R1 repeat", {21'h0, repeatLeft}, 0);
    chk("R1 flags", {29'h0, busy, xferDone, overrunErr}, 0);
    rstN = 1;
    @(negedge clk);

    // run 1: increments everywhere
    cfgSrcAddr = 32'h1000; cfgDstAddr = 32'h2000; cfgBlkBytes = 16'd32; cfgRepeat = 11'd1;
    cfgBurstOff = 16'h8; cfgBlockOff = 16'h100;
    pulse(1, 0, 0, 0, 0);
    chk("R2 src load", srcAddr, 32'h1000);
    chk("R2 dst load", dstAddr, 32'h2000);
    chk("R2 bytes load", {16'h0, bytesLeft}, 32);
    chk("R2 busy", {31'h0, busy}, 1);
    // R10: change configuration while busy
    cfgBurstOff = 16'h40; cfgBlockOff = 16'h7; cfgSrcDec = 1; cfgDstDec = 1;
    cfgBlkSrcDec = 1; cfgBlkDstDec = 1; cfgBlkBytes = 16'd3;
    pulse(0, 1, 16'd8, 0, 0);
    chk("R3 src +burst", srcAddr, 32'h1008);
    chk("R10 held offset", srcAddr, 32'h1008);
    chk("R3 bytes down", {16'h0, bytesLeft}, 24);
    pulse(0, 0, 0, 1, 1);
    chk("R4 dst +burst", dstAddr, 32'h2008);
    chk("R6 early block ignored", {16'h0, bytesLeft}, 24);
    chk("R6 repeat unchanged", {21'h0, repeatLeft}, 1);
    pulse(0, 1, 16'd24, 0, 0);
    chk("R3 bytes zero", {16'h0, bytesLeft}, 0);
    // R5: burst and block in the same cycle
    pulse(0, 0, 0, 1, 1);
    chk("R5 dst burst+block", dstAddr, 32'h2110);
    chk("R5 src block", srcAddr, 32'h1110);
    chk("R5 reload held size", {16'h0, bytesLeft}, 32);
    chk("R5 repeat dec", {21'h0, repeatLeft}, 0);
    pulse(0, 1, 16'd40, 0, 0);
    chk("R8 clamp", {16'h0, bytesLeft}, 0);
    chk("R8 err set", {31'h0, overrunErr}, 1);
    // R8: overrun on the final block boundary, same cycle as block end
    pulse(0, 1, 16'd4, 0, 1);
    chk("R7 done pulse", {31'h0, xferDone}, 1);
    chk("R7 busy low", {31'h0, busy}, 0);
    chk("R8 err sticky", {31'h0, overrunErr}, 1);
    chk("R7 no block offset", srcAddr, 32'h1120);
    pulse(0, 1, 16'd1, 1, 1);
    chk("R7 done one cycle", {31'h0, xferDone}, 0);
    chk("R7 idle src frozen", srcAddr, 32'h1120);
    chk("R7 idle dst frozen", dstAddr, 32'h2110);

    // run 2: mixed directions and wrap
    cfgSrcAddr = 32'h4; cfgDstAddr = 32'hFFFF_FFF8; cfgBlkBytes = 16'd16; cfgRepeat = 11'd2;
    cfgBurstOff = 16'h10; cfgBlockOff = 16'h20;
    cfgSrcDec = 1; cfgDstDec = 0; cfgBlkSrcDec = 0; cfgBlkDstDec = 1;
    pulse(1, 0, 0, 0, 0);
    chk("R2 err cleared", {31'h0, overrunErr}, 0);
    pulse(0, 1, 16'd16, 1, 0);
    chk("R9 src wrap down", srcAddr, 32'hFFFF_FFF4);
    chk("R9 dst wrap up", dstAddr, 32'h0000_0008);
    pulse(0, 0, 0, 0, 1);
    chk("R5 src block add", srcAddr, 32'h0000_0014);
    chk("R5 dst block sub", dstAddr, 32'hFFFF_FFE8);
    chk("R5 repeat 1", {21'h0, repeatLeft}, 1);
    // R5: source burst and block step together
    pulse(0, 1, 16'd16, 0, 0);
    pulse(0, 1, 16'd0, 0, 1);
    chk("R5 src burst+block", srcAddr, 32'h0000_0014);
    // R2: restart mid-transfer wins over strobes
    pulse(1, 1, 16'd5, 1, 1);
    chk("R2 restart src", srcAddr, 32'h4);
    chk("R2 restart bytes", {16'h0, bytesLeft}, 16);

    // pattern sweep compared by the model
    for (int i = 0; i < 200; i++) begin
      pulse(0, (i % 3) == 0, 16'((i * 5) % 9), (i % 4) != 1, (i % 7) == 6);
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule